// File: doc/BRIEF.md
# Phase PWM Output Stage with Shutdown

This block drives one half-bridge of a motor power stage. A free-running tick counter outside the block is shared by all phases. The block compares that tick against a duty value and drives a high-side drive output. It also drives a separate shutdown output that, when high, turns the whole bridge leg off. Three copies are normally placed side by side, one per motor phase, and all of them share the tick counter and the kill line.

Duty and enable settings come in on pending inputs. A preload strobe, pulsed one tick before the counter wraps, copies them into a shadow register. The period-start pulse, seen when the counter returns to zero, moves the shadow into the active register. Duty changes therefore always take effect on a period boundary and never cut a pulse short. The kill input overrides everything without waiting for a clock edge. Until the first complete preload and period-start pair, the stage keeps the bridge off.

Top module: `pwm_phase_stage`

## Requirements
- R1: While reset is asserted, drive_hi is 0 and bridge_off is 1.
- R2: After reset, the outputs stay at drive_hi=0 and bridge_off=1 until a period_start arrives after at least one preload.
- R3: Once armed, with drive enabled and hold-off clear, drive_hi seen after clock edge k equals 1 exactly when the tick sampled at edge k is below the active duty. This gives a one-cycle latency.
- R4: An active duty of 0 keeps drive_hi at 0 for the whole period. An active duty of 2**CW (duty_in bit CW set, other bits 0) keeps drive_hi at 1 for the whole period.
- R5: duty_in, drive_en_in and hold_off_in are captured only on a clock edge where preload is 1. Changes at any other time have no effect on the outputs.
- R6: Captured settings become active at the edge where period_start is 1. That edge's compare already uses the new settings. Without period_start the active settings do not change.
- R7: With the active drive enable at 0, drive_hi stays 0 and bridge_off stays 0 once armed.
- R8: With the active hold-off at 1, bridge_off is 1 and drive_hi is 0.
- R9: While kill is 1, drive_hi is 0 and bridge_off is 1 in the same cycle, with no clock edge needed.
- R10: When kill is released, the outputs return at once to the values the compare and settings give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | CW | Shared period counter value |
| period_start | input | 1 | Pulse when the counter restarts at zero |
| preload | input | 1 | Pulse one tick before the counter wraps; captures the pending inputs |
| kill | input | 1 | Failsafe: forces both transistors off immediately |
| duty_in | input | CW+1 | Pending duty (0 to 2**CW) |
| drive_en_in | input | 1 | Pending enable for the high-side drive |
| hold_off_in | input | 1 | Pending request to hold the bridge leg off |
| drive_hi | output | 1 | High-side PWM drive |
| bridge_off | output | 1 | Bridge shutdown, 1 = leg off |

## Verification
The bench changes the pending inputs to random values through every tick except the preload tick. A stage that captured them at any other time would change its duty in mid-period. It drives duty 0 and the full-scale value 2**CW. An off-by-one compare or a truncated duty width would show a stray pulse or a missing last tick. The kill line is pulsed across a pulse edge. This exposes a stage that waits for a clock to react or that stays latched off after release. The first period after reset is also checked: a stage that drives the bridge before it has been armed would switch on from cleared registers.

// File: rtl/pwm_phase_stage.sv
module pwm_phase_stage #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tick,
  input  logic          period_start,
  input  logic          preload,
  input  logic          kill,
  input  logic [CW:0]   duty_in,
  input  logic          drive_en_in,
  input  logic          hold_off_in,
  output logic          drive_hi,
  output logic          bridge_off
);

  logic [CW:0] sh_duty, act_duty, eff_duty;
  logic        sh_drive, sh_hold, sh_full;
  logic        act_drive, act_hold, armed;
  logic        eff_drive, eff_hold, eff_armed, use_new;
  logic        hi_q, off_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_duty  <= '0;
      sh_drive <= 1'b0;
      sh_hold  <= 1'b0;
      sh_full  <= 1'b0;
    end else if (preload) begin
      sh_duty  <= duty_in;
      sh_drive <= drive_en_in;
      sh_hold  <= hold_off_in;
      sh_full  <= 1'b1;
    end

  assign use_new   = period_start & sh_full;
  assign eff_duty  = use_new ? sh_duty  : act_duty;
  assign eff_drive = use_new ? sh_drive : act_drive;
  assign eff_hold  = use_new ? sh_hold  : act_hold;
  assign eff_armed = armed | use_new;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_duty  <= '0;
      act_drive <= 1'b0;
      act_hold  <= 1'b0;
      armed     <= 1'b0;
    end else if (use_new) begin
      act_duty  <= sh_duty;
      act_drive <= sh_drive;
      act_hold  <= sh_hold;
      armed     <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_q  <= 1'b0;
      off_q <= 1'b1;
    end else begin
      hi_q  <= eff_armed & eff_drive & ~eff_hold & ({1'b0, tick} < eff_duty);
      off_q <= ~eff_armed | eff_hold;
    end

  assign drive_hi   = hi_q & ~kill;
  assign bridge_off = off_q | kill;

  a_r9_kill_forces_safe: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> (!drive_hi && bridge_off));

  a_r2_unarmed_safe: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> bridge_off);

  a_r8_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    drive_hi |-> !bridge_off);

  a_r6_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> $stable(act_duty) && $stable(act_drive) && $stable(act_hold));

  a_r5_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !preload |=> $stable(sh_duty) && $stable(sh_drive) && $stable(sh_hold));

  a_r4_zero_duty_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_duty == '0) |=> !hi_q);

endmodule

// File: tb/tb_pwm_phase_stage.sv
module tb_pwm_phase_stage;
  localparam int CW = 11;
  localparam int PER = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] tick = '0;
  logic period_start = 1'b0, preload = 1'b0, kill = 1'b0;
  logic [CW:0] duty_in = '0;
  logic drive_en_in = 1'b0, hold_off_in = 1'b0;
  logic drive_hi, bridge_off;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model state
  int  m_sh_duty = 0, m_act_duty = 0;
  bit  m_sh_drv = 0, m_sh_hold = 0, m_sh_full = 0;
  bit  m_act_drv = 0, m_act_hold = 0, m_armed = 0;
  bit  m_hi = 0, m_off = 1;

  always #2.5 clk = ~clk;

  pwm_phase_stage #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period_start(period_start),
    .preload(preload), .kill(kill), .duty_in(duty_in),
    .drive_en_in(drive_en_in), .hold_off_in(hold_off_in),
    .drive_hi(drive_hi), .bridge_off(bridge_off));

  function automatic bit exp_hi(bit h, bit k); return h & ~k; endfunction
  function automatic bit exp_off(bit o, bit k); return o | k; endfunction

  task automatic check(string tag);
    bit eh = exp_hi(m_hi, kill);
    bit eo = exp_off(m_off, kill);
    checks++;
    if (drive_hi !== eh || bridge_off !== eo) begin
      errors++;
      $display("FAIL %s tick=%0d: drive_hi=%b bridge_off=%b expected %b %b",
               tag, tick, drive_hi, bridge_off, eh, eo);
    end
  endtask

  // advance model across the next rising edge using the inputs now driven
  task automatic model_edge();
    bit un = period_start && m_sh_full;
    int ed = un ? m_sh_duty : m_act_duty;
    bit edr = un ? m_sh_drv : m_act_drv;
    bit eho = un ? m_sh_hold : m_act_hold;
    bit ea = m_armed | un;
    m_hi  = ea & edr & ~eho & (int'(tick) < ed);
    m_off = ~ea | eho;
    if (un) begin
      m_act_duty = m_sh_duty; m_act_drv = m_sh_drv; m_act_hold = m_sh_hold; m_armed = 1;
    end
    if (preload) begin
      m_sh_duty = int'(duty_in); m_sh_drv = drive_en_in; m_sh_hold = hold_off_in; m_sh_full = 1;
    end
  endtask

  // one period; settings given are loaded at this period's preload tick
  task automatic run_period(int duty, bit drv, bit hold, int ks, int kl, string tag);
    for (int c = 0; c < PER; c++) begin
      @(negedge clk);
      check(tag);
      tick = CW'(c);
      period_start = (c == 0);
      preload = (c == PER - 2);
      kill = (c >= ks) && (c < ks + kl);
      if (preload) begin
        duty_in = (CW+1)'(duty); drive_en_in = drv; hold_off_in = hold;
      end else begin
        duty_in = (CW+1)'($urandom_range(PER, 0));
        drive_en_in = 1'($urandom); hold_off_in = 1'($urandom);
      end
      #0.1;
      check(kill ? "R9" : tag);
      model_edge();
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    #12;
    @(negedge clk);
    check("R1");
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    // no preload before the first start: R2
    run_period(0, 0, 0, PER, 0, "R2");
    run_period(700, 1, 0, PER, 0, "R2");    // loads 700 for next period
    run_period(PER, 1, 0, PER, 0, "R3");    // 700 active here
    run_period(0, 1, 0, PER, 0, "R4");      // full duty active
    run_period(37, 0, 0, PER, 0, "R4");     // zero duty active
    run_period(1500, 1, 1, PER, 0, "R7");   // drive disabled at 37
    run_period(900, 1, 0, PER, 0, "R8");    // hold-off active
    run_period(PER-1, 1, 0, 880, 40, "R10"); // 900 active, kill across edge
    run_period(1, 1, 0, 100, 3, "R6");      // PER-1 active
    for (int p = 0; p < 8; p++) begin
      int d = $urandom_range(PER, 0);
      int ks = $urandom_range(PER - 1, 0);
      run_period(d, 1'($urandom), 1'($urandom), ks, $urandom_range(30, 1), "R3");
    end
    @(negedge clk);
    check("R5");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule